// File: doc/BRIEF.md
# I2C SCL Clock Timing Generator

This block paces the serial clock of an I2C controller from the system clock. The time base is a prescaler that divides by a power of two, with the exponent taken from the timing-control word. Each SCL period is made of a low phase and a high phase, and each phase lasts a programmed number of prescaled ticks. The SCL frequency is therefore the system clock divided by 2^base × ((high+1) + (low+1)).

The block reads only the exponent and the two phase-count fields of the 32-bit timing word. The bus-free, start-hold and setup fields stored in the upper bits of that word are left for other logic. The block asks the pad to pull SCL low during the low phase and releases it during the high phase. High-phase counting waits until the sampled SCL line is actually high, so a target that holds SCL low stretches the period. Three one-cycle strobes go to the bit engine: one where SCL is released, one where it is pulled low again, and one in the middle of the high phase that marks the data sampling point. A build parameter selects a narrow variant with 3-bit phase fields or a wide variant with 4-bit phase fields.

Top module: `scl_timing_gen`

## Requirements
- R1: While `enable` is low, and during reset, `scl_drive_low` and all three strobes stay 0. SCL is released.
- R2: After `enable` rises, `scl_drive_low` is 1 from the next clock edge for exactly (low+1)×2^base cycles. `low` is the phase field at `timing_cfg[15:12]`.
- R3: With no stretching, the high phase (`scl_drive_low` = 0) lasts exactly (high+1)×2^base cycles. `high` is the phase field at `timing_cfg[19:16]`.
- R4: The prescale exponent `base` is the unsigned value of `timing_cfg[3:0]`, and one tick is 2^base system clocks.
- R5: Bits 31:20 and 11:4 of `timing_cfg` have no effect on any output.
- R6: If the sampled `scl_in` is low for k cycles at the start of the high phase, counting starts only when it goes high, and the high phase lasts k + (high+1)×2^base cycles.
- R7: `bit_rise_stb` is 1 only in the first cycle of each high phase. `bit_fall_stb` is 1 only in the first cycle of the low phase that follows a high phase.
- R8: `bit_sample_stb` is a one-cycle pulse that first appears k + (floor(high/2)+1)×2^base cycles after the high phase begins. When high = 0, it falls in the same cycle as `bit_fall_stb`.
- R9: With `WIDE_PHASE` = 0, only the low three bits of each phase field are used (bits 18:16 and 14:12), and bits 19 and 15 are ignored.
- R10: Dropping `enable` releases SCL at the next clock edge. A later re-enable starts a complete low phase from the beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the generator; low holds all counters cleared |
| timing_cfg | input | CFG_W | Timing-control word (exponent, high count, low count) |
| scl_in | input | 1 | Sampled SCL line level |
| scl_drive_low | output | 1 | Request to pull SCL low |
| bit_rise_stb | output | 1 | Pulse in the first cycle of the high phase |
| bit_fall_stb | output | 1 | Pulse in the first cycle of the following low phase |
| bit_sample_stb | output | 1 | Pulse at the middle of the high phase (data sample point) |

## Verification
The sample strobe and the fall strobe come from the same prescaled tick when the high field is zero, so both pulse in one cycle. The bench sets up this case with a zero high count and a large exponent. It then checks that the sample pulse lands on the first cycle of the new low phase, together with the fall strobe, and not inside the high window. The stretch hold and the prescaler restart also fall together: the bench holds `scl_in` low for several cycles after release and expects the whole high phase, and the sample point, to shift by exactly that number of cycles.

// File: rtl/scl_tgen_pkg.sv
package scl_tgen_pkg;

   typedef enum logic {
      PH_LOW  = 1'b0,
      PH_HIGH = 1'b1
   } scl_phase_e;

   function automatic int phase_width(input bit wide);
      return wide ? 4 : 3;
   endfunction

endpackage

// File: rtl/scl_field_decode.sv
module scl_field_decode #(
   parameter int CFG_W    = 32,
   parameter int EXP_W    = 4,
   parameter int PHASE_W  = 4,
   parameter int EXP_LSB  = 0,
   parameter int LOW_LSB  = 12,
   parameter int HIGH_LSB = 16
) (
   input  logic [CFG_W-1:0]   cfg_i,
   output logic [EXP_W-1:0]   exp_o,
   output logic [PHASE_W-1:0] low_o,
   output logic [PHASE_W-1:0] high_o
);

   generate
      if (HIGH_LSB + PHASE_W > CFG_W) begin : g_bad_high
         $error("high field exceeds timing word");
      end
      if (LOW_LSB + PHASE_W > HIGH_LSB) begin : g_bad_low
         $error("low field overlaps high field");
      end
      if (EXP_LSB + EXP_W > LOW_LSB) begin : g_bad_exp
         $error("exponent field overlaps low field");
      end
      if (PHASE_W < 3 || PHASE_W > 4) begin : g_bad_phase
         $error("phase field width must be 3 or 4");
      end
   endgenerate

   assign exp_o  = cfg_i[EXP_LSB  +: EXP_W];
   assign low_o  = cfg_i[LOW_LSB  +: PHASE_W];
   assign high_o = cfg_i[HIGH_LSB +: PHASE_W];

endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
   parameter int EXP_W = 4,
   localparam int CNT_W = (1 << EXP_W) - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             run_i,
   input  logic [EXP_W-1:0] exp_i,
   output logic             tick_o
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] wrap_val;

   generate
      if (EXP_W < 1 || EXP_W > 5) begin : g_bad_exp
         $error("exponent width out of supported range");
      end
   endgenerate

   assign wrap_val = ~({CNT_W{1'b1}} << exp_i);
   assign tick_o   = run_i && !clr_i && (cnt_q == wrap_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (run_i) begin
         cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
      end
   end

   AST_CLR_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && exp_i != '0) |=> (!tick_o || exp_i != $past(exp_i))); // R6

endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer
   import scl_tgen_pkg::*;
#(
   parameter int PHASE_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en_i,
   input  logic               scl_i,
   input  logic               tick_i,
   input  logic [PHASE_W-1:0] low_len_i,
   input  logic [PHASE_W-1:0] high_len_i,
   output logic               pre_run_o,
   output logic               pre_clr_o,
   output logic               drive_low_o,
   output logic               rise_stb_o,
   output logic               fall_stb_o,
   output logic               sample_stb_o
);

   logic               active_q;
   scl_phase_e         phase_q;
   logic [PHASE_W-1:0] cnt_q;
   logic               stall;
   logic [PHASE_W-1:0] mid_idx;

   assign mid_idx     = high_len_i >> 1;
   assign stall       = active_q && (phase_q == PH_HIGH) && !scl_i;
   assign pre_run_o   = active_q && en_i && !stall;
   assign pre_clr_o   = !en_i || !active_q || stall;
   assign drive_low_o = active_q && (phase_q == PH_LOW);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q     <= 1'b0;
         phase_q      <= PH_LOW;
         cnt_q        <= '0;
         rise_stb_o   <= 1'b0;
         fall_stb_o   <= 1'b0;
         sample_stb_o <= 1'b0;
      end else if (!en_i) begin
         active_q     <= 1'b0;
         phase_q      <= PH_LOW;
         cnt_q        <= '0;
         rise_stb_o   <= 1'b0;
         fall_stb_o   <= 1'b0;
         sample_stb_o <= 1'b0;
      end else begin
         active_q     <= 1'b1;
         rise_stb_o   <= 1'b0;
         fall_stb_o   <= 1'b0;
         sample_stb_o <= 1'b0;
         if (tick_i) begin
            if (phase_q == PH_LOW) begin
               if (cnt_q == low_len_i) begin
                  phase_q    <= PH_HIGH;
                  cnt_q      <= '0;
                  rise_stb_o <= 1'b1;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end else begin
               sample_stb_o <= (cnt_q == mid_idx);
               if (cnt_q == high_len_i) begin
                  phase_q    <= PH_LOW;
                  cnt_q      <= '0;
                  fall_stb_o <= 1'b1;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
         end
      end
   end

   AST_RELEASE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(en_i) |-> !drive_low_o); // R1

   AST_RISE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      rise_stb_o |-> (!drive_low_o && $past(drive_low_o))); // R7

   AST_FALL_AT_PULL: assert property (@(posedge clk) disable iff (!rst_n)
      fall_stb_o |-> (drive_low_o && !$past(drive_low_o))); // R7

   AST_SAMPLE_FROM_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      sample_stb_o |-> !$past(drive_low_o)); // R8

   AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (stall && en_i) |=> $stable(cnt_q)); // R6

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
   import scl_tgen_pkg::*;
#(
   parameter bit WIDE_PHASE = 1'b1,
   parameter int CFG_W      = 32,
   parameter int EXP_W      = 4,
   parameter int EXP_LSB    = 0,
   parameter int LOW_LSB    = 12,
   parameter int HIGH_LSB   = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [CFG_W-1:0] timing_cfg,
   input  logic             scl_in,
   output logic             scl_drive_low,
   output logic             bit_rise_stb,
   output logic             bit_fall_stb,
   output logic             bit_sample_stb
);

   localparam int PHASE_W = phase_width(WIDE_PHASE);

   logic [EXP_W-1:0]   exp_f;
   logic [PHASE_W-1:0] low_f;
   logic [PHASE_W-1:0] high_f;
   logic               tick;
   logic               pre_run;
   logic               pre_clr;

   scl_field_decode #(
      .CFG_W    (CFG_W),
      .EXP_W    (EXP_W),
      .PHASE_W  (PHASE_W),
      .EXP_LSB  (EXP_LSB),
      .LOW_LSB  (LOW_LSB),
      .HIGH_LSB (HIGH_LSB)
   ) u_decode (
      .cfg_i  (timing_cfg),
      .exp_o  (exp_f),
      .low_o  (low_f),
      .high_o (high_f)
   );

   scl_prescaler #(
      .EXP_W (EXP_W)
   ) u_prescale (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (pre_clr),
      .run_i  (pre_run),
      .exp_i  (exp_f),
      .tick_o (tick)
   );

   scl_phase_timer #(
      .PHASE_W (PHASE_W)
   ) u_phase (
      .clk          (clk),
      .rst_n        (rst_n),
      .en_i         (enable),
      .scl_i        (scl_in),
      .tick_i       (tick),
      .low_len_i    (low_f),
      .high_len_i   (high_f),
      .pre_run_o    (pre_run),
      .pre_clr_o    (pre_clr),
      .drive_low_o  (scl_drive_low),
      .rise_stb_o   (bit_rise_stb),
      .fall_stb_o   (bit_fall_stb),
      .sample_stb_o (bit_sample_stb)
   );

   AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(bit_rise_stb && (bit_fall_stb || bit_sample_stb))); // R8

endmodule

// File: tb/scl_timing_gen_test.sv
module scl_timing_gen_test;

   localparam int CLK_PERIOD = 10;
   localparam int LOOP_MAX   = 100000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic [31:0] cfg = '0;
   logic        hold_low = 1'b0;
   logic        use_nar = 1'b0;

   wire w_low, w_r, w_f, w_s;
   wire n_low, n_r, n_f, n_s;
   wire w_scl = ~w_low & ~hold_low;
   wire n_scl = ~n_low & ~hold_low;

   scl_timing_gen uut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .timing_cfg(cfg), .scl_in(w_scl),
      .scl_drive_low(w_low), .bit_rise_stb(w_r), .bit_fall_stb(w_f), .bit_sample_stb(w_s));

   scl_timing_gen #(.WIDE_PHASE(1'b0)) uut_narrow (
      .clk(clk), .rst_n(rst_n), .enable(enable), .timing_cfg(cfg), .scl_in(n_scl),
      .scl_drive_low(n_low), .bit_rise_stb(n_r), .bit_fall_stb(n_f), .bit_sample_stb(n_s));

   wire m_low = use_nar ? n_low : w_low;
   wire m_r   = use_nar ? n_r   : w_r;
   wire m_f   = use_nar ? n_f   : w_f;
   wire m_s   = use_nar ? n_s   : w_s;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input int b, input int h, input int l);
      return (32'(h & 15) << 16) | (32'(l & 15) << 12) | 32'(b & 15);
   endfunction

   task automatic restart(input logic [31:0] v, input bit nar);
      @(negedge clk);
      enable = 1'b0;
      repeat (2) @(negedge clk);
      cfg     = v;
      use_nar = nar;
      enable  = 1'b1;
   endtask

   task automatic measure(input int stretch, output int lo, output int hi,
                          output int samp, output int rise, output int fall);
      hold_low = (stretch > 0);
      @(negedge clk);
      lo = 0;
      while (m_low && lo < LOOP_MAX) begin
         lo++;
         @(negedge clk);
      end
      rise = int'(m_r);
      hi   = 0;
      samp = -1;
      while (!m_low && hi < LOOP_MAX) begin
         if (hi == stretch) hold_low = 1'b0;
         if (m_s && samp < 0) samp = hi;
         hi++;
         @(negedge clk);
      end
      fall = int'(m_f);
      if (m_s && samp < 0) samp = hi;
      hold_low = 1'b0;
   endtask

   task automatic run_case(input string tag, input logic [31:0] v, input bit nar,
                           input int b, input int h, input int l, input int stretch);
      int lo, hi, samp, rise, fall, p;
      p = 1 << b;
      restart(v, nar);
      measure(stretch, lo, hi, samp, rise, fall);
      check({tag, " low length"}, lo, (l + 1) * p);
      check({tag, " high length"}, hi, stretch + (h + 1) * p);
      check({tag, " sample point"}, samp, stretch + (h / 2 + 1) * p);
      check({tag, " rise strobe R7"}, rise, 1);
      check({tag, " fall strobe R7"}, fall, 1);
   endtask

   task automatic t_reset();
      int seen;
      seen = 0;
      #(CLK_PERIOD * 2 + 1);
      check("R1 drive in reset", int'(w_low | n_low), 0);
      check("R1 strobes in reset", int'(w_r | w_f | w_s), 0);
      rst_n = 1'b1;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (w_low || w_r || w_f || w_s) seen++;
      end
      check("R1 idle while disabled", seen, 0);
   endtask

   task automatic t_basic();
      run_case("R2 R3 R8 basic", mk(0, 3, 2), 1'b0, 0, 3, 2, 0);
   endtask

   task automatic t_prescale();
      int lo, hi, samp, rise, fall;
      run_case("R4 base2", mk(2, 5, 1), 1'b0, 2, 5, 1, 0);
      restart(mk(6, 0, 0), 1'b0);
      measure(0, lo, hi, samp, rise, fall);
      check("R4 base6 low", lo, 64);
      check("R4 base6 high", hi, 64);
      check("R8 sample with fall when high=0", samp, hi);
      check("R8 fall with sample", fall, 1);
   endtask

   task automatic t_fields();
      run_case("R5 ignored bits", mk(1, 2, 3) | 32'hABC0_0FF0, 1'b0, 1, 2, 3, 0);
   endtask

   task automatic t_max();
      run_case("R2 R3 max fields", mk(0, 15, 15), 1'b0, 0, 15, 15, 0);
   endtask

   task automatic t_stretch();
      run_case("R6 stretch", mk(1, 1, 1), 1'b0, 1, 1, 1, 5);
   endtask

   task automatic t_disable();
      int lo, hi, samp, rise, fall, seen;
      restart(mk(2, 1, 1), 1'b0);
      repeat (3) @(negedge clk);
      check("R10 driving before disable", int'(w_low), 1);
      enable = 1'b0;
      @(negedge clk);
      check("R10 release after disable", int'(w_low), 0);
      seen = 0;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (w_low || w_r || w_f || w_s) seen++;
      end
      check("R1 quiet while disabled", seen, 0);
      enable = 1'b1;
      measure(0, lo, hi, samp, rise, fall);
      check("R10 full low after re-enable", lo, 8);
   endtask

   task automatic t_narrow();
      run_case("R9 narrow fields", mk(0, 10, 9), 1'b1, 0, 2, 1, 0);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   initial begin
      t_reset();
      t_basic();
      t_prescale();
      t_fields();
      t_max();
      t_stretch();
      t_disable();
      t_narrow();
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

endmodule